// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the memory system and holds stores that are still waiting to reach memory. The processor side hands it one word store at a time; the store is taken at once and the processor moves on, while the buffer writes its contents to memory in the background. Each slot covers one aligned block of four 32-bit words. It records the block address, the data for each word and a mask that marks which words have been written.

When a store falls in a block that already has a waiting slot, the word is folded into that slot instead of using a new one. This cuts the number of memory transactions and keeps the buffer from filling up. Slots go to memory oldest first, one slot per transaction, together with the word mask. The oldest slot, which is the one on offer to memory, is closed to further stores, so its payload stays fixed from the moment memory can see it. The store port stalls only when every slot is in use and the incoming store can join none of them.

Top module: `wbuf_top`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `st_ready_o` is 1 and `mem_valid_o` is 0.
- R2: A store that cannot join a waiting slot opens a new slot. Its mask has only bit k set, where k = `st_addr_i[3:2]` is the word index. `mem_addr_o` is the store address with bits [3:0] cleared. Word k of `mem_data_o` lies at bits [32k+31:32k] and holds the store data, and all other words read 0.
- R3: A store to the block of a waiting slot other than the oldest sets mask bit k of that slot and writes word k. A later store to the same word replaces the earlier data.
- R4: The oldest slot never takes a store while it is offered to memory. A store to its block opens a new slot.
- R5: Slots drain oldest first, and each `mem_valid_o`/`mem_ready_i` handshake carries exactly one slot. `mem_valid_o` is 1 in the cycle after a store is taken into an empty buffer, and it stays 1 for as long as any slot is in use.
- R6: `st_ready_o` is 0 only when all 4 slots are in use and the store on the port can join none of them. `mem_ready_i` in the same cycle does not raise it.
- R7: When all slots are in use, a store that can join a waiting slot other than the oldest is still accepted.
- R8: While `mem_valid_o` is 1 and `mem_ready_i` is 0, `mem_addr_o`, `mem_data_o` and `mem_mask_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted when high together with st_valid_i |
| st_addr_i | input | 32 | Byte address of the store |
| st_data_i | input | 32 | Store data word |
| mem_valid_o | output | 1 | A slot is offered to memory |
| mem_ready_i | input | 1 | Memory takes the offered slot |
| mem_addr_o | output | 32 | Block-aligned address of the offered slot |
| mem_data_o | output | 128 | Four data words of the offered slot |
| mem_mask_o | output | 4 | Written-word mask of the offered slot |

## Verification
A store taken at a clock edge is visible on the memory port from that same edge, so `mem_valid_o`, the mask and the address are checked at the falling edge after the accepting edge. `st_ready_o` is combinational from the current slot state and the store on the port, so it is checked at the falling edge before the edge where the store would be taken. A memory transaction is due at the rising edge where `mem_valid_o` and `mem_ready_i` are both high. The monitor samples that condition at the preceding falling edge and compares the payload against the next entry that the driver queued, in order. Inputs change just after rising edges, so every sample sees settled values.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int unsigned WB_ADDR_W = 32;
  localparam int unsigned WB_DATA_W = 32;
  localparam int unsigned WB_WORDS  = 4;
  localparam int unsigned WB_DEPTH  = 4;
endpackage

// File: rtl/wbuf_entry.sv
module wbuf_entry #(
  parameter int unsigned BLK_W  = 28,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    merge_i,
  input  logic                    clr_i,
  input  logic [BLK_W-1:0]        blk_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic                    vld_o,
  output logic [BLK_W-1:0]        blk_o,
  output logic [WORDS-1:0]        mask_o,
  output logic [WORDS*DATA_W-1:0] data_o
);
  logic [WORDS-1:0] sel;
  always_comb begin
    sel = '0;
    sel[widx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      blk_o  <= '0;
      mask_o <= '0;
      data_o <= '0;
    end else if (alloc_i) begin
      vld_o  <= 1'b1;
      blk_o  <= blk_i;
      mask_o <= sel;
      for (int w = 0; w < WORDS; w++)
        data_o[w*DATA_W +: DATA_W] <= sel[w] ? wdata_i : '0;
    end else if (merge_i) begin
      mask_o <= mask_o | sel;
      for (int w = 0; w < WORDS; w++)
        if (sel[w]) data_o[w*DATA_W +: DATA_W] <= wdata_i;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int unsigned BLK_W = 28,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] vld_i,
  input  logic [BLK_W-1:0] blk_i [DEPTH],
  input  logic [PTR_W-1:0] head_i,
  input  logic [BLK_W-1:0] st_blk_i,
  output logic [DEPTH-1:0] hit_o,
  output logic             hit_any_o
);
  // head slot is on offer to memory whenever valid, so it is locked
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit_o[i] = vld_i[i] && (head_i != PTR_W'(i)) && (blk_i[i] == st_blk_i);
  end
  assign hit_any_o = |hit_o;
endmodule

// File: rtl/wbuf_ptrs.sv
module wbuf_ptrs #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o
);
  logic [PTR_W:0] cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o <= '0;
      tail_o <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_o <= nxt(tail_o);
      if (pop_i)  head_o <= nxt(head_o);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign full_o = (cnt_q == (PTR_W+1)'(DEPTH));
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = WB_ADDR_W,
  parameter int unsigned DATA_W = WB_DATA_W,
  parameter int unsigned WORDS  = WB_WORDS,
  parameter int unsigned DEPTH  = WB_DEPTH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [WORDS*DATA_W-1:0] mem_data_o,
  output logic [WORDS-1:0]        mem_mask_o
);
  localparam int unsigned BYTE_W = $clog2(DATA_W/8);
  localparam int unsigned IDX_W  = $clog2(WORDS);
  localparam int unsigned OFF_W  = BYTE_W + IDX_W;
  localparam int unsigned BLK_W  = ADDR_W - OFF_W;
  localparam int unsigned PTR_W  = $clog2(DEPTH);

  logic [BLK_W-1:0]        st_blk;
  logic [IDX_W-1:0]        st_widx;
  logic [DEPTH-1:0]        vld_vec;
  logic [BLK_W-1:0]        blk_arr  [DEPTH];
  logic [WORDS-1:0]        mask_arr [DEPTH];
  logic [WORDS*DATA_W-1:0] data_arr [DEPTH];
  logic [DEPTH-1:0]        hit_vec;
  logic                    hit_any;
  logic [PTR_W-1:0]        head_idx, tail_idx;
  logic                    full;
  logic                    accept, push, pop;

  assign st_blk  = st_addr_i[ADDR_W-1:OFF_W];
  assign st_widx = st_addr_i[OFF_W-1:BYTE_W];

  wbuf_match #(.BLK_W(BLK_W), .DEPTH(DEPTH)) u_match (
    .vld_i     (vld_vec),
    .blk_i     (blk_arr),
    .head_i    (head_idx),
    .st_blk_i  (st_blk),
    .hit_o     (hit_vec),
    .hit_any_o (hit_any)
  );

  assign st_ready_o = !full || hit_any;
  assign accept     = st_valid_i && st_ready_o;
  assign push       = accept && !hit_any;
  assign pop        = mem_valid_o && mem_ready_i;

  wbuf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (pop),
    .head_o (head_idx),
    .tail_o (tail_idx),
    .full_o (full)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    wbuf_entry #(.BLK_W(BLK_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alloc_i (push && (tail_idx == PTR_W'(i))),
      .merge_i (accept && hit_vec[i]),
      .clr_i   (pop && (head_idx == PTR_W'(i))),
      .blk_i   (st_blk),
      .widx_i  (st_widx),
      .wdata_i (st_data_i),
      .vld_o   (vld_vec[i]),
      .blk_o   (blk_arr[i]),
      .mask_o  (mask_arr[i]),
      .data_o  (data_arr[i])
    );
  end

  assign mem_valid_o = vld_vec[head_idx];
  assign mem_addr_o  = {blk_arr[head_idx], OFF_W'(0)};
  assign mem_data_o  = data_arr[head_idx];
  assign mem_mask_o  = mask_arr[head_idx];
endmodule

// File: rtl/wbuf_top_chk.sv
module wbuf_top_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    st_ready_o,
  input logic                    mem_valid_o,
  input logic                    mem_ready_i,
  input logic [ADDR_W-1:0]       mem_addr_o,
  input logic [WORDS*DATA_W-1:0] mem_data_o,
  input logic [WORDS-1:0]        mem_mask_o,
  input logic [DEPTH-1:0]        vld_vec,
  input logic [DEPTH-1:0]        hit_vec,
  input logic [PTR_W-1:0]        head_idx
);
  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> st_ready_o && !mem_valid_o);

  a_r3_single_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  a_r4_head_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_vec[head_idx]);

  a_r5_offer_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|vld_vec) |-> mem_valid_o);

  a_r6_stall_only_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !st_ready_o |-> ($countones(vld_vec) == DEPTH));

  a_r8_payload_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=>
      (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o) && $stable(mem_mask_o)));
endmodule

bind wbuf_top wbuf_top_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_ready_o  (st_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_mask_o  (mem_mask_o),
  .vld_vec     (vld_vec),
  .hit_vec     (hit_vec),
  .head_idx    (head_idx)
);

// File: tb/wbuf_top_tb.sv
module wbuf_top_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         st_valid_i = 1'b0;
  logic         st_ready_o;
  logic [31:0]  st_addr_i = '0;
  logic [31:0]  st_data_i = '0;
  logic         mem_valid_o;
  logic         mem_ready_i = 1'b0;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_data_o;
  logic [3:0]   mem_mask_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct packed {
    logic [31:0]  addr;
    logic [3:0]   mask;
    logic [127:0] data;
  } txn_t;
  txn_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wbuf_top u_dut (.*);

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic expect_txn(input logic [31:0] a, input logic [3:0] m,
                            input logic [31:0] w3, input logic [31:0] w2,
                            input logic [31:0] w1, input logic [31:0] w0);
    txn_t t;
    t.addr = a; t.mask = m; t.data = {w3, w2, w1, w0};
    exp_q.push_back(t);
  endtask

  // inputs change just after a rising edge; task returns just after the accepting edge
  task automatic store(input logic [31:0] a, input logic [31:0] d);
    st_valid_i = 1'b1; st_addr_i = a; st_data_i = d;
    forever begin
      @(negedge clk_i);
      if (st_ready_o) break;
    end
    @(posedge clk_i); #1;
    st_valid_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // scoreboard monitor: handshake due at next rising edge
  always @(negedge clk_i) begin
    if (rst_ni && mem_valid_o && mem_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected memory write", {96'b0, mem_addr_o}, 128'b0);
      end else begin
        txn_t e;
        e = exp_q.pop_front();
        check(mem_addr_o == e.addr, "R5 drain order addr", {96'b0, mem_addr_o}, {96'b0, e.addr});
        check(mem_mask_o == e.mask, "R3 drain mask", {124'b0, mem_mask_o}, {124'b0, e.mask});
        check(mem_data_o == e.data, "R2 drain data", mem_data_o, e.data);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
          check(1'b0, "watchdog expired", 128'b0, 128'b1);
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
  end

  initial begin
    // R1 reset state
    @(negedge clk_i);
    check(st_ready_o == 1'b1, "R1 ready in reset", {127'b0, st_ready_o}, 128'd1);
    check(mem_valid_o == 1'b0, "R1 mem_valid in reset", {127'b0, mem_valid_o}, 128'd0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(st_ready_o && !mem_valid_o, "R1 idle after reset", {126'b0, st_ready_o, mem_valid_o}, 128'd2);
    @(posedge clk_i); #1;

    // R2/R5 single store into empty buffer
    store(32'h0000_0104, 32'hAAAA_0001);
    @(negedge clk_i);
    check(mem_valid_o, "R5 valid cycle after accept", {127'b0, mem_valid_o}, 128'd1);
    check(mem_mask_o == 4'b0010, "R2 new slot mask", {124'b0, mem_mask_o}, 128'b0010);
    check(mem_addr_o == 32'h0000_0100, "R2 block address", {96'b0, mem_addr_o}, 128'h100);
    check(mem_data_o == {32'h0, 32'h0, 32'hAAAA_0001, 32'h0}, "R2 zero fill",
          mem_data_o, {32'h0, 32'h0, 32'hAAAA_0001, 32'h0});
    expect_txn(32'h100, 4'b0010, 32'h0, 32'h0, 32'hAAAA_0001, 32'h0);
    @(posedge clk_i); #1;
    mem_ready_i = 1'b1;
    idle(3);
    @(negedge clk_i);
    check(!mem_valid_o, "R5 empty after drain", {127'b0, mem_valid_o}, 128'd0);
    @(posedge clk_i); #1;

    // R3/R4 merging with memory stalled
    mem_ready_i = 1'b0;
    store(32'h0000_0200, 32'h0000_00A0);
    store(32'h0000_0300, 32'h0000_00C0);
    store(32'h0000_0308, 32'h0000_00B0);
    store(32'h0000_0308, 32'h0000_00D0);
    store(32'h0000_020C, 32'h0000_00E0);
    @(negedge clk_i);
    check(mem_mask_o == 4'b0001, "R4 head slot untouched", {124'b0, mem_mask_o}, 128'b0001);
    check(mem_data_o == {96'h0, 32'hA0}, "R8 head data held", mem_data_o, {96'h0, 32'hA0});
    expect_txn(32'h200, 4'b0001, 32'h0, 32'h0, 32'h0, 32'hA0);
    expect_txn(32'h300, 4'b0101, 32'h0, 32'hD0, 32'h0, 32'hC0);
    expect_txn(32'h200, 4'b1000, 32'hE0, 32'h0, 32'h0, 32'h0);
    @(posedge clk_i); #1;
    mem_ready_i = 1'b1;
    idle(6);
    check(exp_q.size() == 0, "R5 all slots drained", exp_q.size(), 128'd0);

    // R6/R7 full buffer
    mem_ready_i = 1'b0;
    store(32'h0000_1000, 32'h11);
    store(32'h0000_2000, 32'h22);
    store(32'h0000_3000, 32'h33);
    store(32'h0000_4000, 32'h44);
    st_valid_i = 1'b1; st_addr_i = 32'h0000_5000; st_data_i = 32'h55;
    @(negedge clk_i);
    check(!st_ready_o, "R6 stall when full and no match", {127'b0, st_ready_o}, 128'd0);
    @(posedge clk_i); #1;
    st_valid_i = 1'b0;
    st_addr_i = 32'h0000_1004;
    @(negedge clk_i);
    check(!st_ready_o, "R6 head block cannot absorb when full", {127'b0, st_ready_o}, 128'd0);
    @(posedge clk_i); #1;
    st_addr_i = 32'h0000_2004; st_data_i = 32'h2B; st_valid_i = 1'b1;
    @(negedge clk_i);
    check(st_ready_o, "R7 merge accepted when full", {127'b0, st_ready_o}, 128'd1);
    @(posedge clk_i); #1;
    st_valid_i = 1'b0;
    expect_txn(32'h1000, 4'b0001, 32'h0, 32'h0, 32'h0, 32'h11);
    expect_txn(32'h2000, 4'b0011, 32'h0, 32'h0, 32'h2B, 32'h22);
    expect_txn(32'h3000, 4'b0001, 32'h0, 32'h0, 32'h0, 32'h33);
    expect_txn(32'h4000, 4'b0001, 32'h0, 32'h0, 32'h0, 32'h44);
    expect_txn(32'h5000, 4'b0001, 32'h0, 32'h0, 32'h0, 32'h55);
    mem_ready_i = 1'b1;
    st_valid_i = 1'b1; st_addr_i = 32'h0000_5000; st_data_i = 32'h55;
    @(negedge clk_i);
    check(!st_ready_o, "R6 mem_ready does not raise ready", {127'b0, st_ready_o}, 128'd0);
    @(posedge clk_i); #1;
    store(32'h0000_5000, 32'h55);
    idle(8);
    check(exp_q.size() == 0, "R5 full drain complete", exp_q.size(), 128'd0);
    @(negedge clk_i);
    check(!mem_valid_o && st_ready_o, "R5 idle at end", {126'b0, mem_valid_o, st_ready_o}, 128'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule